// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It drives three switch controls on an external analog integrator. One discharges the integrator. One connects the unknown input. One connects a reference whose polarity is opposite to the input. It also watches a comparator that tells when the integrator output has returned through zero.

A conversion is requested with a start pulse while the block is idle. The sequence is:

1. A discharge phase whose length is taken from a length input at the moment of start.
2. An input integration phase that lasts exactly one full turn of the phase counter, 2^CNT_W clock cycles.
3. A reference de-integration phase. The counter restarts from zero in this phase and counts until the comparator reports the crossing.

The count, less the fixed latency of the comparator synchroniser, is the conversion result. When no crossing arrives within the allowed window, the block gives up, raises an overrange flag and reports a saturated result. A single-cycle valid strobe marks each new result.

The controller states are:

| State | Meaning |
|---|---|
| IDLE | waiting for start |
| AZERO | discharge |
| GAP_A | all switches open |
| INTEG | input integration |
| GAP_B | all switches open |
| DEINT | reference de-integration |
| DONE | result valid |

The transitions are:

- start: IDLE to AZERO
- discharge done: AZERO to GAP_A
- always: GAP_A to INTEG
- counter wrap: INTEG to GAP_B
- always: GAP_B to DEINT
- crossing or timeout: DEINT to DONE
- always: DONE to IDLE

Top module: `dsadc_ctrl`

## Requirements
- R1: While reset is held and after release, all three switch outputs are low, valid is low, result is 0 and overrange is 0.
- R2: A high start sampled in IDLE captures az_len and begins discharge. sw_reset is high for L = max(az_len, 1) consecutive cycles, and later changes of az_len do not alter that conversion.
- R3: At most one switch output is high in any cycle. Exactly one cycle with all switches low separates discharge from integration, and separates integration from de-integration.
- R4: sw_input is high for exactly 2^CNT_W consecutive cycles per conversion.
- R5: Number the sw_ref cycles from 0. Let c be the first such cycle whose closing edge samples cmp_in high, with cmp_in high meaning the zero crossing has been reached. Then for c ≤ 2^CNT_W, result = c and overrange = 0.
- R6: A crossing at c = 2^CNT_W, which is detected in the same cycle as the timeout limit, still gives result = 2^CNT_W with overrange = 0.
- R7: If no crossing is seen by cycle 2^CNT_W, then result = all ones (2^(CNT_W+1)−1) and overrange = 1. sw_ref stays high no longer than 2^CNT_W + SYNC_N + 1 cycles.
- R8: valid is high for one cycle per conversion, in the cycle that begins L + 2^CNT_W + c + SYNC_N + 3 rising edges after the edge that sampled start. For overrange, c is taken as 2^CNT_W. result and overrange hold their values until the next valid.
- R9: start outside IDLE has no effect on the running conversion. cmp_in levels sampled before the first de-integration cycle do not count as a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | conversion request, honoured in IDLE |
| az_len | input | AZ_W | discharge phase length in cycles (0 treated as 1) |
| cmp_in | input | 1 | asynchronous comparator, high once integrator crossed zero |
| sw_reset | output | 1 | integrator discharge switch |
| sw_input | output | 1 | input connect switch |
| sw_ref | output | 1 | opposite-polarity reference connect switch |
| result | output | CNT_W+1 | de-integration count |
| overrange | output | 1 | no crossing within the window |
| valid | output | 1 | one-cycle result strobe |

## Verification
In DEINT, crossing detection and the timeout limit can occur in the same cycle. This happens when the comparator first reads high in cycle 2^CNT_W, because its synchronised level then arrives exactly at the count where the timeout fires. The bench provokes this by raising cmp_in on that exact de-integration cycle, counted from the first cycle it observes sw_ref high. It expects a full-scale result without the overrange flag. It then runs a conversion one cycle later (never crossing) and expects the saturated overrange result. A further conversion holds cmp_in high through the earlier phases and drops it at the start of de-integration. This checks that stale synchroniser contents are not taken for a crossing.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AZERO = 3'd1,
        ST_GAP_A = 3'd2,
        ST_INTEG = 3'd3,
        ST_GAP_B = 3'd4,
        ST_DEINT = 3'd5,
        ST_DONE  = 3'd6
    } dsadc_state_e;

endpackage

// File: rtl/dsadc_sync.sv
// Multi-stage level synchroniser for the asynchronous comparator output.
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
// Phase counter shared by all timed phases; synchronous clear wins over count.
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/dsadc_ctrl.sv
// Dual-slope integrating converter sequencer (top).
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int AZ_W   = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AZ_W-1:0]  az_len,
    input  logic             cmp_in,
    output logic             sw_reset,
    output logic             sw_input,
    output logic             sw_ref,
    output logic [CNT_W:0]   result,
    output logic             overrange,
    output logic             valid
);
    localparam int NMAX   = 1 << CNT_W;
    localparam int RES_W  = CNT_W + 1;
    localparam int DCNT_W = CNT_W + 2;
    localparam int CW     = (DCNT_W > AZ_W) ? DCNT_W : AZ_W;
    localparam logic [CW-1:0] INT_LAST = CW'(NMAX - 1);
    localparam logic [CW-1:0] TMO_CNT  = CW'(NMAX + SYNC_N);
    localparam logic [CW-1:0] SYNC_CNT = CW'(SYNC_N);

    dsadc_state_e state_q, state_nx;

    logic [CW-1:0]   cnt;
    logic            cnt_clr;
    logic            cmp_s;
    logic [AZ_W-1:0] az_q;
    logic [CW-1:0]   az_last;
    logic            hit;
    logic            tmo;

    // ---- comparator synchroniser ----
    dsadc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    // ---- shared phase counter: restarts on every state change ----
    assign cnt_clr = (state_nx != state_q);

    dsadc_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (1'b1),
        .q     (cnt)
    );

    // ---- discharge length captured at start ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            az_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            az_q <= az_len;
        end
    end

    assign az_last = (az_q == '0) ? '0 : (CW'(az_q) - CW'(1));

    // ---- de-integration events ----
    // Synchroniser contents are ignored until SYNC_N cycles into DEINT, so
    // only comparator samples taken within the phase can stop the count.
    assign hit = cmp_s && (cnt >= SYNC_CNT);
    assign tmo = (cnt == TMO_CNT);

    // ---- next-state logic ----
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)              state_nx = ST_AZERO;
            ST_AZERO: if (cnt == az_last)     state_nx = ST_GAP_A;
            ST_GAP_A:                         state_nx = ST_INTEG;
            ST_INTEG: if (cnt == INT_LAST)    state_nx = ST_GAP_B;
            ST_GAP_B:                         state_nx = ST_DEINT;
            ST_DEINT: if (hit || tmo)         state_nx = ST_DONE;
            ST_DONE:                          state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // ---- result register: crossing takes priority over the timeout ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (state_q == ST_DEINT) begin
            if (hit) begin
                result    <= RES_W'(cnt - SYNC_CNT);
                overrange <= 1'b0;
            end else if (tmo) begin
                result    <= '1;
                overrange <= 1'b1;
            end
        end
    end

    // ---- Moore outputs ----
    always_comb begin
        sw_reset = 1'b0;
        sw_input = 1'b0;
        sw_ref   = 1'b0;
        valid    = 1'b0;
        unique case (state_q)
            ST_AZERO: sw_reset = 1'b1;
            ST_INTEG: sw_input = 1'b1;
            ST_DEINT: sw_ref   = 1'b1;
            ST_DONE:  valid    = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/dsadc_ctrl_chk.sv
// Property checker for dsadc_ctrl, attached with bind below.
module dsadc_ctrl_chk #(
    parameter int CNT_W  = 6,
    parameter int SYNC_N = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sw_reset,
    input logic           sw_input,
    input logic           sw_ref,
    input logic [CNT_W:0] result,
    input logic           overrange,
    input logic           valid
);
    localparam int NMAX = 1 << CNT_W;
    localparam int RW   = CNT_W + 3;

    logic [RW-1:0] in_run;
    logic [RW-1:0] ref_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_run  <= '0;
            ref_run <= '0;
        end else begin
            in_run  <= sw_input ? in_run + RW'(1) : '0;
            ref_run <= sw_ref ? ref_run + RW'(1) : '0;
        end
    end

    a_r3_onehot_switches: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_reset, sw_input, sw_ref}));

    a_r3_gap_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_reset) |-> (!sw_input && !sw_ref));

    a_r3_gap_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> !sw_ref);

    a_r3_gap_before_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_input) |-> $past(!sw_reset));

    a_r4_integrate_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> (in_run == RW'(NMAX)));

    a_r7_ref_window: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ref |-> (ref_run <= RW'(NMAX + SYNC_N)));

    a_r7_overrange_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && overrange) |-> (&result));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(result) && $stable(overrange)));

    a_r5_valid_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(sw_ref));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(
    .CNT_W  (CNT_W),
    .SYNC_N (SYNC_N)
) u_dsadc_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_reset  (sw_reset),
    .sw_input  (sw_input),
    .sw_ref    (sw_ref),
    .result    (result),
    .overrange (overrange),
    .valid     (valid)
);

// File: tb/test_dsadc_ctrl.sv
module test_dsadc_ctrl;
    localparam int CNT_W  = 6;
    localparam int AZ_W   = 4;
    localparam int SYNC_N = 2;
    localparam int NMAX   = 1 << CNT_W;
    localparam int SAT    = (1 << (CNT_W + 1)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AZ_W-1:0] az_len = '0;
    logic            cmp_in = 1'b0;
    logic            sw_reset, sw_input, sw_ref;
    logic [CNT_W:0]  result;
    logic            overrange, valid;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    int    q_res[$];
    int    q_ovr[$];
    int    q_due[$];
    string q_tag[$];

    dsadc_ctrl #(.CNT_W(CNT_W), .AZ_W(AZ_W), .SYNC_N(SYNC_N)) i_dsadc_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .az_len    (az_len),
        .cmp_in    (cmp_in),
        .sw_reset  (sw_reset),
        .sw_input  (sw_input),
        .sw_ref    (sw_ref),
        .result    (result),
        .overrange (overrange),
        .valid     (valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // monitor: pops one expected item per valid strobe
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R8 unexpected valid", 1, 0);
            end else begin
                int    e_res, e_ovr, e_due;
                string tg;
                e_res = q_res.pop_front();
                e_ovr = q_ovr.pop_front();
                e_due = q_due.pop_front();
                tg    = q_tag.pop_front();
                check(int'(result) == e_res, {tg, " result"}, int'(result), e_res);
                check(int'(overrange) == e_ovr, {tg, " overrange"}, int'(overrange), e_ovr);
                check(cyc == e_due, "R8 valid timing", cyc, e_due);
            end
        end
    end

    // driver: one conversion; c > NMAX means the comparator never trips
    task automatic run_conv(input int az, input int c, input bit pre_hi,
                            input bit poke, input string tag);
        int L, cc, e_res, n_rst, n_in, n_gapbad, k;
        logic [2:0] prev_sw, cur_sw;
        L     = (az == 0) ? 1 : az;
        cc    = (c > NMAX) ? NMAX : c;
        e_res = (c > NMAX) ? SAT : c;
        @(negedge clk);
        az_len = AZ_W'(az);
        start  = 1'b1;
        if (pre_hi) cmp_in = 1'b1;
        q_res.push_back(e_res);
        q_ovr.push_back((c > NMAX) ? 1 : 0);
        q_due.push_back(cyc + 1 + L + NMAX + 3 + cc + SYNC_N);
        q_tag.push_back(tag);
        @(negedge clk);
        start  = 1'b0;
        az_len = ~AZ_W'(az);           // R2: must not affect this conversion
        n_rst = 0; n_in = 0; n_gapbad = 0; prev_sw = 3'b000;
        while (!sw_ref) begin
            cur_sw = {sw_reset, sw_input, sw_ref};
            if (sw_reset) n_rst++;
            if (sw_input) n_in++;
            if ($countones(cur_sw) > 1) n_gapbad++;
            if (prev_sw != 3'b000 && cur_sw != 3'b000 && prev_sw != cur_sw) n_gapbad++;
            prev_sw = cur_sw;
            start = (poke && sw_input && n_in == 10);   // R9: ignored start
            @(negedge clk);
        end
        start = 1'b0;
        check(n_rst == L, "R2 discharge length", n_rst, L);
        check(n_in == NMAX, "R4 integrate length", n_in, NMAX);
        check(n_gapbad == 0, "R3 switch overlap/gap", n_gapbad, 0);
        check(prev_sw == 3'b000, "R3 gap before de-integration", int'(prev_sw), 0);
        cmp_in = 1'b0;                 // R9: earlier high levels must not count
        k = 0;
        while (!valid) begin
            if (k == c) cmp_in = 1'b1;
            k++;
            @(negedge clk);
        end
        check({sw_reset, sw_input, sw_ref} == 3'b000, "R3 switches open at result",
              int'({sw_reset, sw_input, sw_ref}), 0);
        cmp_in = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(result) == e_res && !valid, "R8 result held", int'(result), e_res);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({sw_reset, sw_input, sw_ref, valid} == 4'b0, "R1 outputs in reset",
              int'({sw_reset, sw_input, sw_ref, valid}), 0);
        check(result == '0 && !overrange, "R1 result in reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({sw_reset, sw_input, sw_ref, valid} == 4'b0, "R1 idle after reset",
              int'({sw_reset, sw_input, sw_ref, valid}), 0);

        run_conv(3, 10, 1'b0, 1'b0, "R5");
        run_conv(0, 5, 1'b0, 1'b0, "R2");
        run_conv(15, 0, 1'b0, 1'b0, "R5");
        run_conv(2, 20, 1'b1, 1'b0, "R9");
        run_conv(1, NMAX, 1'b0, 1'b0, "R6");
        run_conv(4, NMAX + 1, 1'b0, 1'b0, "R7");
        run_conv(2, 33, 1'b0, 1'b1, "R9");
        run_conv(5, 1, 1'b0, 1'b0, "R5");
        run_conv(1, NMAX - 1, 1'b0, 1'b0, "R6");

        repeat (5) @(negedge clk);
        check(q_res.size() == 0, "R8 missing valid", q_res.size(), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end
endmodule